// File: doc/BRIEF.md
# Delta-Sigma Bitstream Density Decoder with Clip Detection

This block takes a single-bit delta-sigma modulator stream and turns it into a 16-bit unsigned code that is proportional to the density of ones. Bits arrive one per clock, gated by a valid qualifier. The block counts the ones over a window of 2^WIN_LOG2 consumed bits. It scales that count to a 16-bit full scale, saturates the result at 65535, and presents it with a one-clock strobe once the last bit of the window has been consumed. With the default 65536-bit window, a stream that is 50% ones yields 32768. A stream that is 89.0625% ones yields 58368, and one that is 10.9375% ones yields 7168.

In parallel, the block watches the run lengths of identical bits to recognise the pattern a modulator emits when its input is beyond full scale. That pattern is one level held for a long run, broken by a lone opposite bit roughly every 128 bits. Positive clipping shows as ones with a single zero marker. Negative clipping shows as zeros with a single one marker. A line that does not toggle at all for 256 bits is reported as stuck, not as clipped.

Top module: `bitstream_density_decoder`

## Requirements
- R1: A synchronous reset, sampled on the rising edge of `clk`, clears the code to 0 and drops `code_vld`, `clip_pos`, `clip_neg` and `stuck`. It also clears the window position, the ones count and the run tracking, so the next consumed bit starts a fresh window.
- R2: After each block of 2^WIN_LOG2 consumed bits, `code` takes the value min(ones x 2^(16-WIN_LOG2), 65535), where "ones" is the number of ones in that block. `code_vld` is high for exactly the one cycle that follows the clock edge consuming the final bit. `code` holds its value between strobes.
- R3: The following densities give the following codes: 50% gives 32768, 89.0625% gives 58368, 10.9375% gives 7168, and 0% gives 0.
- R4: A window made entirely of ones saturates to 65535.
- R5: A cycle with `bit_vld` low consumes nothing. Its `bit_in` value changes neither the code, the window position nor any flag.
- R6: The following sequence sets `clip_pos` on the edge that consumes its final one, and clears `clip_neg` and `stuck` at the same edge: a run of at least 127 ones, then exactly one zero, then a one.
- R7: The following sequence sets `clip_neg` on the edge that consumes its final zero, and clears `clip_pos` and `stuck` at the same edge: a run of at least 127 zeros, then exactly one one, then a zero.
- R8: A run of ones shorter than 120 clears `clip_pos` at the edge that consumes the zero ending the run. A run of zeros shorter than 120 clears `clip_neg` at the edge that consumes the one ending the run. A run of 120 or more leaves the flag set.
- R9: A run of 256 identical consumed bits raises `stuck` at the edge consuming the 256th bit and clears both clip flags. `stuck` drops at the next change of level.
- R10: A 126-bit run followed by a lone opposite bit does not set a clip flag. Neither does a run of at least 127 followed by two opposite bits.
- R11: At most one of `clip_pos`, `clip_neg` and `stuck` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Qualifies `bit_in` for consumption |
| bit_in | input | 1 | Modulator bitstream input |
| code | output | 16 | Scaled, saturated ones count of the last window |
| code_vld | output | 1 | One-cycle strobe for a new `code` |
| clip_pos | output | 1 | Positive saturation pattern detected |
| clip_neg | output | 1 | Negative saturation pattern detected |
| stuck | output | 1 | No level change for 256 consumed bits |

## Verification
The bench aims at the run-length thresholds one bit either side of each limit. A detector that is off by one would flag a 126-bit run, or would miss a 127-bit run. It would also clear on a 120-bit majority run, or raise the stuck flag at 255 bits. An all-ones window and the exact 89.0625% and 10.9375% densities are checked, because a scaler without saturation would wrap the full window to 0. A shift placed wrongly would miss the codes 58368 and 7168. Random idle cycles carrying random data are interleaved throughout. A design that counted bits while the valid input was low would therefore drift its window boundary and its codes. The bench also moves from negative to positive clipping and from clipping to stuck. This catches flags that never release one another.

// File: rtl/bitstream_density_decoder.sv
module bitstream_density_decoder #(
  parameter int WIN_LOG2   = 16,
  parameter int CODE_W     = 16,
  parameter int CLIP_RUN   = 127,
  parameter int LINEAR_RUN = 120,
  parameter int STUCK_RUN  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_vld,
  input  logic              bit_in,
  output logic [CODE_W-1:0] code,
  output logic              code_vld,
  output logic              clip_pos,
  output logic              clip_neg,
  output logic              stuck
);
  localparam int ACC_W = WIN_LOG2 + 1;
  localparam int SCL_W = CODE_W + 1;
  localparam int SHIFT = CODE_W - WIN_LOG2;
  localparam int RUN_W = $clog2(STUCK_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_CLIP   = RUN_W'(CLIP_RUN);
  localparam logic [RUN_W-1:0] RUN_LIN    = RUN_W'(LINEAR_RUN);
  localparam logic [RUN_W-1:0] RUN_STUCK  = RUN_W'(STUCK_RUN);
  localparam logic [RUN_W-1:0] RUN_PRESTK = RUN_W'(STUCK_RUN - 1);

  logic [WIN_LOG2-1:0] bit_cnt;
  logic [ACC_W-1:0]    ones_acc;
  logic [RUN_W-1:0]    run_len;
  logic                last_bit, have_bit, pend, pend_lvl;

  wire              flip      = have_bit && (bit_in != last_bit);
  wire              win_end   = &bit_cnt;
  wire [ACC_W-1:0]  ones_next = ones_acc + ACC_W'(bit_in);
  wire [SCL_W-1:0]  scaled    = SCL_W'(ones_next) << SHIFT;
  wire [CODE_W-1:0] sat_code  = scaled[CODE_W] ? '1 : scaled[CODE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      ones_acc <= '0;
      run_len  <= '0;
      last_bit <= 1'b0;
      have_bit <= 1'b0;
      pend     <= 1'b0;
      pend_lvl <= 1'b0;
      code     <= '0;
      code_vld <= 1'b0;
      clip_pos <= 1'b0;
      clip_neg <= 1'b0;
      stuck    <= 1'b0;
    end else begin
      code_vld <= 1'b0;
      if (bit_vld) begin
        bit_cnt  <= bit_cnt + 1'b1;
        have_bit <= 1'b1;
        last_bit <= bit_in;
        if (win_end) begin
          ones_acc <= '0;
          code     <= sat_code;
          code_vld <= 1'b1;
        end else begin
          ones_acc <= ones_next;
        end

        if (!flip) begin
          pend <= 1'b0;
          if (run_len != RUN_STUCK) run_len <= run_len + 1'b1;
          if (run_len == RUN_PRESTK) begin
            stuck    <= 1'b1;
            clip_pos <= 1'b0;
            clip_neg <= 1'b0;
          end
        end else begin
          run_len  <= RUN_W'(1);
          stuck    <= 1'b0;
          pend     <= (run_len >= RUN_CLIP);
          pend_lvl <= last_bit;
          if (run_len < RUN_LIN) begin
            if (last_bit) clip_pos <= 1'b0;
            else          clip_neg <= 1'b0;
          end
          if (pend) begin
            clip_pos <= pend_lvl;
            clip_neg <= !pend_lvl;
          end
        end
      end
    end
  end
endmodule

// File: rtl/bitstream_density_decoder_chk.sv
module bitstream_density_decoder_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_vld,
  input logic              bit_in,
  input logic [CODE_W-1:0] code,
  input logic              code_vld,
  input logic              clip_pos,
  input logic              clip_neg,
  input logic              stuck
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (code == '0 && !code_vld && !clip_pos && !clip_neg && !stuck)); // R1

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    code_vld |=> !code_vld); // R2

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!code_vld && !$past(rst)) |-> $stable(code)); // R2

  AST_IDLE_INERT: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> (!code_vld && $stable({clip_pos, clip_neg, stuck}))); // R5

  AST_POS_ON_ONE: assert property (@(posedge clk) disable iff (rst)
    $rose(clip_pos) |-> $past(bit_vld && bit_in)); // R6

  AST_NEG_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(clip_neg) |-> $past(bit_vld && !bit_in)); // R7

  AST_STUCK_ON_BIT: assert property (@(posedge clk) disable iff (rst)
    $rose(stuck) |-> $past(bit_vld)); // R9

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clip_pos, clip_neg, stuck})); // R11
endmodule

bind bitstream_density_decoder bitstream_density_decoder_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .code(code),
  .code_vld(code_vld), .clip_pos(clip_pos), .clip_neg(clip_neg), .stuck(stuck)
);

// File: tb/bitstream_density_decoder_tb_top.sv
module bitstream_density_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_LOG2   = 10;
  localparam int WIN        = 1 << WIN_LOG2;
  localparam int SHIFT      = 16 - WIN_LOG2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic [15:0] code;
  logic code_vld, clip_pos, clip_neg, stuck;

  int total = 0;
  int bad = 0;
  logic s_vld;
  logic [15:0] s_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitstream_density_decoder #(.WIN_LOG2(WIN_LOG2)) dut_i (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .code(code),
    .code_vld(code_vld), .clip_pos(clip_pos), .clip_neg(clip_neg), .stuck(stuck)
  );

  function automatic int exp_code(int ones);
    int v = ones << SHIFT;
    return (v > 65535) ? 65535 : v;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(string req, int exp);
    int act = {29'd0, clip_pos, clip_neg, stuck};
    chk(act == exp, req, act, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    bit_vld = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send(bit b);
    if ($urandom_range(0, 7) == 0) begin
      @(negedge clk);
      bit_in = 1'($urandom);
      @(posedge clk);
    end
    @(negedge clk);
    bit_vld = 1'b1;
    bit_in = b;
    @(posedge clk);
    #2;
    s_vld = code_vld;
    s_code = code;
    bit_vld = 1'b0;
  endtask

  task automatic sendn(bit b, int k);
    for (int i = 0; i < k; i++) send(b);
  endtask

  task automatic do_window(int n, bit rnd, string req);
    int cnt = 0;
    int early = 0;
    for (int i = 0; i < WIN; i++) begin
      bit b;
      if (rnd) b = ($urandom_range(0, WIN - 1) < n);
      else     b = (((i + 1) * n) / WIN) != ((i * n) / WIN);
      cnt += int'(b);
      send(b);
      if (i < WIN - 1 && s_vld) early++;
    end
    chk(early == 0, {req, " strobe early"}, early, 0);
    chk(s_vld == 1'b1, {req, " strobe"}, int'(s_vld), 1);
    chk(int'(s_code) == exp_code(cnt), {req, " code"}, int'(s_code), exp_code(cnt));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7731));
    do_reset();
    #2;
    chk(code == 16'd0 && !code_vld, "R1 code after reset", int'(code), 0);
    chk_flags("R1 flags after reset", 0);

    do_window(WIN / 2, 1'b0, "R3 50%");
    chk(int'(s_code) == 32768, "R3 50% literal", int'(s_code), 32768);
    do_window(912, 1'b0, "R3 89.06%");
    chk(int'(s_code) == 58368, "R3 89% literal", int'(s_code), 58368);
    do_window(112, 1'b0, "R3 10.94%");
    chk(int'(s_code) == 7168, "R3 10% literal", int'(s_code), 7168);
    do_window(0, 1'b0, "R3 zero");
    do_window(WIN, 1'b0, "R4 all ones");
    chk(int'(s_code) == 65535, "R4 saturate", int'(s_code), 65535);
    for (int w = 0; w < 6; w++) do_window(int'($urandom_range(0, WIN)), 1'b1, "R2 random window");

    for (int i = 0; i < 300; i++) send(1'($urandom));
    do_reset();
    do_window(WIN / 2, 1'b0, "R1 window restarts");

    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      bit_in = ~bit_in;
    end
    @(posedge clk);
    #2;
    chk(!code_vld && int'(code) == 32768, "R5 idle code", int'(code), 32768);

    do_reset();
    sendn(1'b1, 127);
    send(1'b0);
    chk_flags("R6 not yet after marker", 0);
    send(1'b1);
    chk_flags("R6 clip_pos set", 4);
    sendn(1'b1, 126);
    send(1'b0);
    send(1'b1);
    chk_flags("R6 held in pattern", 4);
    sendn(1'b1, 119);
    send(1'b0);
    chk_flags("R8 run of 120 keeps", 4);
    send(1'b1);
    sendn(1'b1, 118);
    send(1'b0);
    chk_flags("R8 run of 119 clears", 0);

    do_reset();
    sendn(1'b0, 130);
    send(1'b1);
    send(1'b0);
    chk_flags("R7 clip_neg set", 2);
    sendn(1'b0, 126);
    sendn(1'b1, 127);
    send(1'b0);
    send(1'b1);
    chk_flags("R7 neg to pos swap", 4);
    send(1'b0);
    chk_flags("R8 short ones run clears", 0);

    do_reset();
    sendn(1'b1, 126);
    send(1'b0);
    send(1'b1);
    chk_flags("R10 run 126 ignored", 0);
    do_reset();
    sendn(1'b0, 140);
    sendn(1'b1, 2);
    send(1'b0);
    chk_flags("R10 double marker ignored", 0);

    do_reset();
    sendn(1'b1, 255);
    chk_flags("R9 no stuck at 255", 0);
    send(1'b1);
    chk_flags("R9 stuck at 256", 1);
    send(1'b0);
    chk_flags("R9 stuck clears on change", 0);
    send(1'b1);
    chk_flags("R6 clip after stuck run", 4);
    sendn(1'b1, 255);
    chk_flags("R9 stuck clears clip", 1);
    do_reset();
    #2;
    chk_flags("R1 flags cleared", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule